// File: doc/BRIEF.md
# ULPI PHY Register Access Engine

This block sits on the PHY side of an 8-bit ULPI link bus. While the bus is idle it keeps the direction output low, so the data pins are inputs and it listens for transmit commands from the link. A command byte whose top two bits are `10` starts a register write and `11` starts a register read. The low six bits give the address. The address escape value 2Fh means that a full 8-bit address byte follows the command. The engine answers with NXT and, for reads, turns the bus around to return one byte. It then hands the bus back to the link.

Five control registers each take up three consecutive addresses. A write to the first replaces the value, a write to the second ORs the byte in, and a write to the third clears the bits that are set in the byte. The triples start at 04h (function control), 07h (interface control), 0Ah (OTG control), 0Dh (rising-edge interrupt enable) and 3Dh (power control). Address 00h returns a fixed vendor identifier. Addresses 13h and 15h return live status and debug bytes from the rest of the PHY. A receive request from the PHY takes the bus at once and aborts any register access that is in progress.

Top module: `ulpi_reg_engine`

## Requirements
- R1: After reset, dir and nxt are low. The registers read as follows: function control 41h, interface control 00h, OTG control 06h (bits 7 and 6 clear), interrupt enable 1Fh, power control 00h.
- R2: For a write command (bits 7:6 = `10`), nxt is high in the cycle after the command byte is sampled. The data byte is sampled in that cycle. The write takes effect when stp is high in the cycle after the data byte.
- R3: A write to the second address of a triple ORs the data byte into the register.
- R4: A write to the third address of a triple ANDs the complement of the data byte into the register.
- R5: For a read command (bits 7:6 = `11`), nxt is high for one cycle. dir is then high for two cycles, and the read data is on dout in the second of them. dir then falls. nxt and dir are never high together.
- R6: The command address 2Fh is an escape. The next byte on the bus, sampled in a cycle while nxt is high, becomes the full 8-bit address, and the access then continues as an immediate access.
- R7: Address 00h reads the vendor byte CCh, 13h reads `irq_stat`, and 15h reads `dbg_stat`. Writes to these addresses change nothing.
- R8: When `rx_req` is high at a clock edge, dir is high and dout equals `rx_data` in the next cycle. Any access in progress is dropped, and no register changes.
- R9: A write whose data byte is not followed by stp in the next cycle is discarded.
- R10: `suspend_n` follows bit 6 of function control, and `prot_dis` follows bit 7 of interface control.
- R11: A read of any address outside the map, including extended addresses from 40h up, returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Data bus driven by the link |
| stp | input | 1 | Link stop strobe |
| rx_req | input | 1 | PHY request to take the bus for receive data |
| rx_data | input | 8 | Byte the PHY drives while it holds the bus |
| irq_stat | input | 8 | Live interrupt status byte |
| dbg_stat | input | 8 | Live debug byte |
| dout | output | 8 | Data bus driven by the PHY while dir is high |
| dir | output | 1 | Bus direction, high when the PHY drives |
| nxt | output | 1 | Command and byte acknowledge |
| suspend_n | output | 1 | Active-low suspend control |
| prot_dis | output | 1 | Interface-protect disable |

## Verification
The assertions assume that the link follows the command sequence. The link drives 00h while it is idle, presents the next byte only in a cycle where nxt is high, and raises stp only in the cycle after the data byte. The bench keeps to this by driving every byte from per-access tasks that advance one clock at a time against the expected nxt/dir pattern. It drives 00h on din during turnaround cycles. It raises `rx_req` only at fixed points inside an access, or while the bus is idle.

// File: rtl/ulpi_reg_engine.sv
module ulpi_reg_engine #(
  parameter logic [7:0] VID_LO   = 8'hCC,
  parameter logic [7:0] FUNC_RST = 8'h41,
  parameter logic [7:0] OTG_RST  = 8'h06,
  parameter logic [7:0] IEN_RST  = 8'h1F,
  parameter int         NREG     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] din,
  input  logic       stp,
  input  logic       rx_req,
  input  logic [7:0] rx_data,
  input  logic [7:0] irq_stat,
  input  logic [7:0] dbg_stat,
  output logic [7:0] dout,
  output logic       dir,
  output logic       nxt,
  output logic       suspend_n,
  output logic       prot_dis
);
  localparam logic [5:0] EXT_ESC = 6'h2F;
  localparam logic [7:0] BASE [NREG] = '{8'h04, 8'h07, 8'h0A, 8'h0D, 8'h3D};
  localparam logic [7:0] RSTV [NREG] = '{FUNC_RST, 8'h00, OTG_RST, IEN_RST, 8'h00};

  typedef enum logic [2:0] {S_IDLE, S_WACK, S_WSTP, S_RACK, S_RTA1, S_RDAT, S_RTA2} st_t;
  st_t state;
  logic [7:0] addr, wdata, rd;
  logic       ext, rx_own, commit;
  logic [7:0] regs [NREG];
  logic [NREG*8-1:0] regs_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; addr <= '0; wdata <= '0; ext <= 1'b0; rx_own <= 1'b0;
    end else begin
      rx_own <= rx_req;
      if (rx_req) begin
        state <= S_IDLE; ext <= 1'b0;
      end else begin
        case (state)
          S_IDLE: if (!rx_own && din[7]) begin
            addr  <= {2'b00, din[5:0]};
            ext   <= (din[5:0] == EXT_ESC);
            state <= din[6] ? S_RACK : S_WACK;
          end
          S_WACK: if (ext) begin
            addr <= din; ext <= 1'b0;
          end else begin
            wdata <= din; state <= S_WSTP;
          end
          S_WSTP: state <= S_IDLE;
          S_RACK: begin
            if (ext) addr <= din;
            ext <= 1'b0; state <= S_RTA1;
          end
          S_RTA1: state <= S_RDAT;
          S_RDAT: state <= S_RTA2;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign commit = (state == S_WSTP) && stp && !rx_req;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] off;
    assign off = addr - BASE[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= RSTV[g];
      else if (commit) begin
        case (off)
          8'd0: regs[g] <= wdata;
          8'd1: regs[g] <= regs[g] | wdata;
          8'd2: regs[g] <= regs[g] & ~wdata;
          default: ;
        endcase
      end
    end
    assign regs_flat[g*8 +: 8] = regs[g];
  end

  always_comb begin
    rd = 8'h00;
    if (addr == 8'h00) rd = VID_LO;
    if (addr == 8'h13) rd = irq_stat;
    if (addr == 8'h15) rd = dbg_stat;
    for (int i = 0; i < NREG; i++)
      if (8'(addr - BASE[i]) < 8'd3) rd = regs[i];
  end

  assign dir       = rx_own || state == S_RTA1 || state == S_RDAT;
  assign nxt       = state == S_WACK || state == S_RACK;
  assign dout      = rx_own ? rx_data : (state == S_RDAT ? rd : 8'h00);
  assign suspend_n = regs[0][6];
  assign prot_dis  = regs[1][7];

  AST_CMD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !rx_own && !rx_req && din[7:6] == 2'b10) |=> nxt); // R2
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nxt && dir)); // R5
  AST_DIR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDAT && !rx_req) |=> !dir); // R5
  AST_RX_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n) rx_req |=> dir); // R8
  AST_RX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_req |=> $stable(regs_flat)); // R8
  AST_NO_STP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !stp |=> $stable(regs_flat)); // R9
endmodule

// File: tb/ulpi_reg_engine_bench.sv
module ulpi_reg_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0, stp = 1'b0, rx_req = 1'b0;
  logic [7:0] din = 8'h00, rx_data = 8'hE7, irq_stat = 8'hA3, dbg_stat = 8'h3C;
  logic [7:0] dout;
  logic dir, nxt, suspend_n, prot_dis;
  int vectors = 0, miscompares = 0, cycles = 0;

  always #10 clk = ~clk;

  ulpi_reg_engine u_ulpi_reg_engine (
    .clk(clk), .rst_n(rst_n), .din(din), .stp(stp), .rx_req(rx_req),
    .rx_data(rx_data), .irq_stat(irq_stat), .dbg_stat(dbg_stat),
    .dout(dout), .dir(dir), .nxt(nxt), .suspend_n(suspend_n), .prot_dis(prot_dis));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #2; endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d, logic ext);
    din = ext ? 8'hAF : {2'b10, a[5:0]}; tick();
    chk("R2 nxt after write cmd", {7'd0, nxt}, 8'd1);
    if (ext) begin
      din = a; tick();
      chk("R6 nxt after ext addr", {7'd0, nxt}, 8'd1);
    end
    din = d; tick();
    chk("R2 nxt low after data", {7'd0, nxt}, 8'd0);
    din = 8'h00; stp = 1'b1; tick(); stp = 1'b0;
  endtask

  task automatic do_read(logic [7:0] a, logic ext, output logic [7:0] v);
    din = ext ? 8'hEF : {2'b11, a[5:0]}; tick();
    chk("R5 nxt ack read", {6'd0, nxt, dir}, 8'b10);
    din = ext ? a : 8'h00; tick(); din = 8'h00;
    chk("R5 turnaround 1", {6'd0, nxt, dir}, 8'b01);
    tick();
    chk("R5 data cycle", {6'd0, nxt, dir}, 8'b01);
    v = dout;
    tick();
    chk("R5 dir falls", {6'd0, nxt, dir}, 8'b00);
    tick();
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 dir/nxt reset", {6'd0, dir, nxt}, 8'd0);
    do_read(8'h04, 0, v); chk("R1 func reset", v, 8'h41);
    do_read(8'h07, 0, v); chk("R1 intf reset", v, 8'h00);
    do_read(8'h0A, 0, v); chk("R1 otg reset", v, 8'h06);
    do_read(8'h0D, 0, v); chk("R1 ien reset", v, 8'h1F);
    do_read(8'h3D, 0, v); chk("R1 pwr reset", v, 8'h00);
    chk("R10 suspend_n reset", {7'd0, suspend_n}, 8'd1);
  endtask

  task automatic t_modes;
    logic [7:0] v;
    do_write(8'h04, 8'h55, 0); do_read(8'h04, 0, v); chk("R2 plain write", v, 8'h55);
    do_write(8'h06, 8'h40, 0); do_read(8'h04, 0, v); chk("R4 clear", v, 8'h15);
    chk("R10 suspend_n low", {7'd0, suspend_n}, 8'd0);
    do_write(8'h05, 8'h82, 0); do_read(8'h06, 0, v); chk("R3 set", v, 8'h97);
    do_write(8'h0E, 8'h20, 0); do_read(8'h0D, 0, v); chk("R3 set ien", v, 8'h3F);
    do_write(8'h07, 8'h80, 0);
    chk("R10 prot_dis", {7'd0, prot_dis}, 8'd1);
  endtask

  task automatic t_extended;
    logic [7:0] v;
    do_write(8'h3D, 8'h5A, 1); do_read(8'h3D, 0, v); chk("R6 ext write", v, 8'h5A);
    do_read(8'h0A, 1, v); chk("R6 ext read", v, 8'h06);
    do_write(8'h3F, 8'h0A, 1); do_read(8'h3E, 1, v); chk("R6 R4 ext clear", v, 8'h50);
    do_read(8'h80, 1, v); chk("R11 ext unmapped", v, 8'h00);
    do_read(8'h20, 0, v); chk("R11 unmapped", v, 8'h00);
  endtask

  task automatic t_readonly;
    logic [7:0] v;
    do_read(8'h00, 0, v); chk("R7 vendor", v, 8'hCC);
    do_read(8'h13, 0, v); chk("R7 irq_stat", v, 8'hA3);
    irq_stat = 8'h5E;
    do_read(8'h13, 0, v); chk("R7 irq_stat live", v, 8'h5E);
    do_read(8'h15, 0, v); chk("R7 dbg_stat", v, 8'h3C);
    do_write(8'h00, 8'hFF, 0); do_read(8'h00, 0, v); chk("R7 vendor write ignored", v, 8'hCC);
  endtask

  task automatic t_nostp;
    logic [7:0] v;
    din = 8'h8A; tick(); din = 8'hFF; tick(); din = 8'h00; tick();
    do_read(8'h0A, 0, v); chk("R9 no stp discarded", v, 8'h06);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    din = 8'h84; tick(); din = 8'h00; rx_data = 8'hE7; rx_req = 1'b1; tick();
    chk("R8 dir on rx", {7'd0, dir}, 8'd1);
    chk("R8 rx_data on bus", dout, 8'hE7);
    rx_req = 1'b0; tick(); stp = 1'b1; tick(); stp = 1'b0;
    do_read(8'h04, 0, v); chk("R8 write aborted", v, 8'h97);
    din = 8'h84; tick(); din = 8'h00; tick(); stp = 1'b1; rx_req = 1'b1; tick();
    stp = 1'b0; rx_req = 1'b0; tick();
    do_read(8'h04, 0, v); chk("R8 commit aborted", v, 8'h97);
    din = 8'hC4; tick(); din = 8'h00; tick(); rx_data = 8'h3B; rx_req = 1'b1; tick();
    chk("R8 read replaced", dout, 8'h3B);
    rx_req = 1'b0; tick();
    chk("R8 bus released", {6'd0, dir, nxt}, 8'd0);
    tick();
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      vectors++; miscompares++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      report();
    end
  end

  initial begin
    #25; rst_n = 1'b1; tick();
    t_reset();
    t_modes();
    t_extended();
    t_readonly();
    t_nostp();
    t_abort();
    report();
  end
endmodule